// File: doc/BRIEF.md
# Host Processor to DSP Expansion Bus Bridge

This block is the synchronous glue between a 32-bit big-endian host processor and a DSP expansion bus in synchronous host-port mode. The host is an external master: its transfer-start strobe, address, transfer size, read/write and burst-in-progress signals become the expansion bus address strobe, chip select, active-low byte enables, active-high burst-last and read/write. The expansion ready line comes back as the host's transfer acknowledge. The data lanes are connected in mirrored bit order, because the two buses number their most significant bit from opposite ends.

A second state machine handles bus ownership. The arbiter on the DSP side owns the bus. The host's request, grant and busy handshake is therefore converted to hold and hold-acknowledge. All registers run on the single shared bus clock.

Transfer machine states: `XF_IDLE` (waiting for a strobe) and `XF_BEAT` (chip select held, beats acknowledged). Transitions: `XF_IDLE -> XF_BEAT` when the start strobe is low and the address hits the window. `XF_BEAT -> XF_IDLE` on a beat with ready low and burst-in-progress high. Arbitration machine states: `AR_IDLE`, `AR_WAIT_ACK` (hold raised) and `AR_GRANTED` (grant given to the host). Transitions: `AR_IDLE -> AR_WAIT_ACK` when a request is seen with the bus not busy. `AR_WAIT_ACK -> AR_GRANTED` when hold-acknowledge is seen. `AR_WAIT_ACK -> AR_IDLE` if the request is withdrawn first. `AR_GRANTED -> AR_IDLE` when request and busy are both released.

Top module: `hostbus_xbus_bridge`

## Requirements
- R1: After reset, xas_n, xcs_n and host_ta_n are 1, xbe_n is 4'b1111, xhold is 0, host_bg_n is 1, xblast is 0 and size_err is 0.
- R2: With host_ts_n low at a clock edge in idle, and an address where (host_addr & WIN_MASK) == (WIN_BASE & WIN_MASK), xas_n is low for exactly the one cycle after that edge. xcs_n goes low from the same edge.
- R3: A start strobe whose address misses the window leaves xas_n, xcs_n and host_ta_n high.
- R4: For byte transfers (host_tsize = 2'b01), xbe_n follows the low address bits {host_addr[1], host_addr[0]}, where host_addr[0] is the least significant address bit. The values are 00 -> 0111, 01 -> 1011, 10 -> 1101, 11 -> 1110.
- R5: For a halfword (host_tsize = 2'b10), xbe_n is 0011 when host_addr[1] = 0 and 1100 when host_addr[1] = 1. For a word (host_tsize = 2'b00), xbe_n is 0000. The value is latched at the start of the transfer.
- R6: For host_tsize = 2'b11, xbe_n is 1111 and size_err is 1 for the whole transfer.
- R7: The data lanes are mirrored: xd_out[31-i] = host_wdata[i] and host_rdata[31-i] = xd_in[i].
- R8: xrnw holds host_rnw as sampled at the start edge. While xcs_n is low, xblast equals host_bdip_n. It is 0 otherwise.
- R9: While xcs_n is low, host_ta_n equals xrdy_n. It is 1 otherwise.
- R10: xcs_n stays low through wait states and burst beats. It goes high at the edge after a beat where xrdy_n is low and host_bdip_n is high.
- R11: xhold rises at the edge where host_br_n is low and host_bb_n is high. A request while busy raises no hold.
- R12: host_bg_n falls at the edge where xholda is seen high with hold raised. Grant and hold both stay until host_br_n and host_bb_n are both high, and both drop at that edge.
- R13: A start strobe during an active transfer is ignored. xas_n stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus clock |
| rst_n | input | 1 | Active-low reset |
| host_ts_n | input | 1 | Host transfer start |
| host_addr | input | 32 | Host address, bit 0 least significant |
| host_tsize | input | 2 | Host transfer size |
| host_rnw | input | 1 | Host read (1) / write (0) |
| host_bdip_n | input | 1 | Host burst-in-progress, low while more beats follow |
| host_wdata | input | 32 | Host write data, bit 0 most significant |
| host_rdata | output | 32 | Read data to host, bit 0 most significant |
| host_ta_n | output | 1 | Transfer acknowledge to host |
| host_br_n | input | 1 | Host bus request |
| host_bb_n | input | 1 | Host bus busy |
| host_bg_n | output | 1 | Bus grant to host |
| xas_n | output | 1 | Expansion address strobe |
| xcs_n | output | 1 | Expansion chip select |
| xbe_n | output | 4 | Expansion byte enables, active low |
| xblast | output | 1 | Expansion burst-last, active high |
| xrnw | output | 1 | Expansion read/write |
| xd_out | output | 32 | Expansion write data, bit 31 most significant |
| xd_in | input | 32 | Expansion read data, bit 31 most significant |
| xrdy_n | input | 1 | Expansion ready |
| xhold | output | 1 | Hold request to the expansion arbiter |
| xholda | input | 1 | Hold acknowledge from the expansion arbiter |
| size_err | output | 1 | Unsupported transfer size in the current transfer |

## Verification
The bench walks all eight size and offset combinations, including the reserved size. A decoder with a swapped lane or a misread half bit would light the wrong bytes. A bridge that forgot the reserved code would enable lanes instead of flagging it.

Bursts with wait states are checked for three failure modes:
- a chip select that drops on the first acknowledged beat instead of the last;
- an acknowledge that leaks outside a transfer;
- a burst-last that inverts the burst-in-progress sense.

A second start strobe inside a burst must not re-strobe. A request while the bus is busy must not raise hold. A grant must not arrive before hold-acknowledge. The grant must survive while the host still holds busy.

// File: rtl/glue_pkg.sv
package glue_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned LANES  = DATA_W / 8;

    localparam logic [1:0] SZ_WORD = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;
    localparam logic [1:0] SZ_HALF = 2'b10;
    localparam logic [1:0] SZ_RSVD = 2'b11;

    typedef enum logic {
        XF_IDLE,
        XF_BEAT
    } xfer_state_t;

    typedef enum logic [1:0] {
        AR_IDLE,
        AR_WAIT_ACK,
        AR_GRANTED
    } arb_state_t;
endpackage

// File: rtl/lane_decode.sv
module lane_decode
    import glue_pkg::*;
#(
    parameter int unsigned N_LANES = LANES
) (
    input  logic [1:0]         tsize,
    input  logic [1:0]         offset,
    output logic [N_LANES-1:0] lane_en_n,
    output logic               bad_size
);
    localparam logic [N_LANES-1:0] TOP_LANE  = {1'b1, {(N_LANES-1){1'b0}}};
    localparam logic [N_LANES-1:0] HIGH_HALF = {{(N_LANES/2){1'b1}}, {(N_LANES/2){1'b0}}};

    always_comb begin
        lane_en_n = '1;
        bad_size  = 1'b0;
        unique case (tsize)
            SZ_BYTE: lane_en_n = ~(TOP_LANE >> offset);
            SZ_HALF: lane_en_n = offset[1] ? ~(HIGH_HALF >> (N_LANES/2)) : ~HIGH_HALF;
            SZ_WORD: lane_en_n = '0;
            SZ_RSVD: begin
                lane_en_n = '1;
                bad_size  = 1'b1;
            end
        endcase
    end

    always_comb begin
        assert_bad_inactive_R6: assert (!bad_size || (lane_en_n == '1));
    end
endmodule

// File: rtl/lane_mirror.sv
module lane_mirror #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] src,
    output logic [W-1:0] dst
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dst[W-1-i] = src[i];
    end
endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
    import glue_pkg::*;
#(
    parameter int unsigned N_LANES = LANES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ts_n,
    input  logic               hit,
    input  logic               rnw_in,
    input  logic               bdip_n,
    input  logic               rdy_n,
    input  logic [N_LANES-1:0] dec_en_n,
    input  logic               dec_bad,
    output logic               as_n,
    output logic               cs_n,
    output logic [N_LANES-1:0] en_n,
    output logic               rnw_out,
    output logic               blast,
    output logic               ta_n,
    output logic               err
);
    xfer_state_t state_q, state_d;
    logic start, finish;

    assign start  = (state_q == XF_IDLE) && !ts_n && hit;
    assign finish = (state_q == XF_BEAT) && !rdy_n && bdip_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_IDLE: if (start)  state_d = XF_BEAT;
            XF_BEAT: if (finish) state_d = XF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= XF_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            as_n    <= 1'b1;
            en_n    <= '1;
            rnw_out <= 1'b1;
            err     <= 1'b0;
        end else begin
            as_n <= !start;
            if (start) begin
                en_n    <= dec_en_n;
                rnw_out <= rnw_in;
                err     <= dec_bad;
            end else if (finish) begin
                en_n <= '1;
                err  <= 1'b0;
            end
        end
    end

    assign cs_n  = (state_q != XF_BEAT);
    assign blast = (state_q == XF_BEAT) && bdip_n;
    assign ta_n  = (state_q != XF_BEAT) || rdy_n;

    assert_as_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |=> as_n);
    assert_as_with_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |-> !cs_n);
    assert_ack_in_xfer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ta_n |-> !cs_n);
    assert_cs_end_on_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $past(!rdy_n && bdip_n));
    assert_err_lanes_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (en_n == '1));
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import glue_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic br_n,
    input  logic bb_n,
    input  logic holda,
    output logic hold,
    output logic bg_n
);
    arb_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AR_IDLE:     if (!br_n && bb_n)  state_d = AR_WAIT_ACK;
            AR_WAIT_ACK: if (holda)          state_d = AR_GRANTED;
                         else if (br_n)      state_d = AR_IDLE;
            AR_GRANTED:  if (br_n && bb_n)   state_d = AR_IDLE;
            default:                         state_d = AR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= AR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        hold = (state_q != AR_IDLE);
        bg_n = (state_q != AR_GRANTED);
    end

    assert_hold_needs_free_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> $past(!br_n && bb_n));
    assert_grant_after_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bg_n) |-> $past(holda));
    assert_grant_under_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bg_n |-> hold);
endmodule

// File: rtl/hostbus_xbus_bridge.sv
module hostbus_xbus_bridge
    import glue_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h8000_0000,
    parameter logic [ADDR_W-1:0] WIN_MASK = 32'hFF00_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_ts_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [1:0]        host_tsize,
    input  logic              host_rnw,
    input  logic              host_bdip_n,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ta_n,
    input  logic              host_br_n,
    input  logic              host_bb_n,
    output logic              host_bg_n,
    output logic              xas_n,
    output logic              xcs_n,
    output logic [LANES-1:0]  xbe_n,
    output logic              xblast,
    output logic              xrnw,
    output logic [DATA_W-1:0] xd_out,
    input  logic [DATA_W-1:0] xd_in,
    input  logic              xrdy_n,
    output logic              xhold,
    input  logic              xholda,
    output logic              size_err
);
    logic             hit;
    logic [LANES-1:0] dec_en_n;
    logic             dec_bad;

    assign hit = ((host_addr & WIN_MASK) == (WIN_BASE & WIN_MASK));

    lane_decode #(.N_LANES(LANES)) u_dec (
        .tsize     (host_tsize),
        .offset    (host_addr[1:0]),
        .lane_en_n (dec_en_n),
        .bad_size  (dec_bad)
    );

    xfer_fsm #(.N_LANES(LANES)) u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ts_n     (host_ts_n),
        .hit      (hit),
        .rnw_in   (host_rnw),
        .bdip_n   (host_bdip_n),
        .rdy_n    (xrdy_n),
        .dec_en_n (dec_en_n),
        .dec_bad  (dec_bad),
        .as_n     (xas_n),
        .cs_n     (xcs_n),
        .en_n     (xbe_n),
        .rnw_out  (xrnw),
        .blast    (xblast),
        .ta_n     (host_ta_n),
        .err      (size_err)
    );

    arb_fsm u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .br_n  (host_br_n),
        .bb_n  (host_bb_n),
        .holda (xholda),
        .hold  (xhold),
        .bg_n  (host_bg_n)
    );

    lane_mirror #(.W(DATA_W)) u_wr_mirror (.src(host_wdata), .dst(xd_out));
    lane_mirror #(.W(DATA_W)) u_rd_mirror (.src(xd_in),      .dst(host_rdata));
endmodule

// File: tb/hostbus_xbus_bridge_bench.sv
module hostbus_xbus_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_ts_n = 1'b1;
    logic [31:0] host_addr = '0;
    logic [1:0]  host_tsize = '0;
    logic        host_rnw = 1'b0;
    logic        host_bdip_n = 1'b1;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ta_n;
    logic        host_br_n = 1'b1;
    logic        host_bb_n = 1'b1;
    logic        host_bg_n;
    logic        xas_n, xcs_n, xblast, xrnw, xhold, size_err;
    logic [3:0]  xbe_n;
    logic [31:0] xd_out;
    logic [31:0] xd_in = '0;
    logic        xrdy_n = 1'b1;
    logic        xholda = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    hostbus_xbus_bridge u_hostbus_xbus_bridge (.*);

    // {tsize, offset, expected xbe_n, expected size_err}
    localparam logic [8:0] VEC [8] = '{
        {2'b01, 2'b00, 4'b0111, 1'b0},
        {2'b01, 2'b01, 4'b1011, 1'b0},
        {2'b01, 2'b10, 4'b1101, 1'b0},
        {2'b01, 2'b11, 4'b1110, 1'b0},
        {2'b10, 2'b00, 4'b0011, 1'b0},
        {2'b10, 2'b10, 4'b1100, 1'b0},
        {2'b00, 2'b00, 4'b0000, 1'b0},
        {2'b11, 2'b00, 4'b1111, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic to_neg();
        @(negedge clk);
    endtask

    task automatic after_pos();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 20000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) to_neg();
        // R1 reset values
        chk("R1 xas_n", {31'd0, xas_n}, 32'd1);
        chk("R1 xcs_n", {31'd0, xcs_n}, 32'd1);
        chk("R1 xbe_n", {28'd0, xbe_n}, 32'hF);
        chk("R1 xhold", {31'd0, xhold}, 32'd0);
        chk("R1 host_bg_n", {31'd0, host_bg_n}, 32'd1);
        chk("R1 host_ta_n", {31'd0, host_ta_n}, 32'd1);
        chk("R1 size_err", {31'd0, size_err}, 32'd0);
        rst_n = 1'b1;
        to_neg();

        // Vector table: single-beat transfers (R4, R5, R6, R2, R9, R10)
        for (int k = 0; k < 8; k++) begin
            string tag;
            tag = (VEC[k][8:7] == 2'b01) ? "R4" : (VEC[k][8:7] == 2'b11) ? "R6" : "R5";
            host_addr  = 32'h8000_0000 | {30'd0, VEC[k][6:5]};
            host_tsize = VEC[k][8:7];
            host_rnw   = k[0];
            host_ts_n  = 1'b0;
            after_pos();
            chk({tag, " xbe_n"}, {28'd0, xbe_n}, {28'd0, VEC[k][4:1]});
            chk({tag, " size_err"}, {31'd0, size_err}, {31'd0, VEC[k][0]});
            chk("R2 xas_n low", {31'd0, xas_n}, 32'd0);
            chk("R8 xrnw", {31'd0, xrnw}, {31'd0, k[0]});
            to_neg();
            host_ts_n = 1'b1;
            host_tsize = 2'b00;
            host_addr[1:0] = 2'b00;
            xrdy_n = 1'b0;
            #1;
            chk("R9 ta follows ready", {31'd0, host_ta_n}, 32'd0);
            after_pos();
            chk("R2 xas_n one cycle", {31'd0, xas_n}, 32'd1);
            chk("R10 cs released", {31'd0, xcs_n}, 32'd1);
            to_neg();
            xrdy_n = 1'b1;
        end

        // R3 address miss
        host_addr = 32'h4000_0000;
        host_ts_n = 1'b0;
        after_pos();
        chk("R3 miss xas_n", {31'd0, xas_n}, 32'd1);
        chk("R3 miss xcs_n", {31'd0, xcs_n}, 32'd1);
        to_neg();
        host_ts_n = 1'b1;
        xrdy_n = 1'b0;
        #1;
        chk("R3 miss ta", {31'd0, host_ta_n}, 32'd1);
        xrdy_n = 1'b1;

        // Burst read with a wait state (R8, R9, R10, R13)
        host_addr = 32'h8000_0010;
        host_rnw = 1'b1;
        host_tsize = 2'b00;
        host_ts_n = 1'b0;
        host_bdip_n = 1'b0;
        after_pos();
        chk("R8 burst xrnw", {31'd0, xrnw}, 32'd1);
        chk("R8 blast low mid burst", {31'd0, xblast}, 32'd0);
        to_neg();
        host_ts_n = 1'b1;
        #1;
        chk("R9 wait state ta", {31'd0, host_ta_n}, 32'd1);
        after_pos();
        chk("R10 cs held in wait", {31'd0, xcs_n}, 32'd0);
        to_neg();
        xrdy_n = 1'b0;
        host_ts_n = 1'b0;
        after_pos();
        chk("R10 cs held after first beat", {31'd0, xcs_n}, 32'd0);
        chk("R13 no restrobe", {31'd0, xas_n}, 32'd1);
        to_neg();
        host_ts_n = 1'b1;
        host_bdip_n = 1'b1;
        #1;
        chk("R8 blast on last", {31'd0, xblast}, 32'd1);
        after_pos();
        chk("R10 cs released after last", {31'd0, xcs_n}, 32'd1);
        chk("R8 blast idle", {31'd0, xblast}, 32'd0);
        to_neg();
        xrdy_n = 1'b1;

        // R7 lane mirror
        host_wdata = 32'h0000_0001;
        xd_in = 32'h0000_0003;
        #1;
        chk("R7 write mirror", xd_out, 32'h8000_0000);
        chk("R7 read mirror", host_rdata, 32'hC000_0000);
        host_wdata = 32'h1234_5678;
        #1;
        chk("R7 write pattern", xd_out, 32'h1E6A_2C48);

        // Arbitration (R11, R12)
        host_br_n = 1'b0;
        host_bb_n = 1'b0;
        after_pos();
        chk("R11 no hold while busy", {31'd0, xhold}, 32'd0);
        to_neg();
        host_bb_n = 1'b1;
        after_pos();
        chk("R11 hold raised", {31'd0, xhold}, 32'd1);
        chk("R12 no grant before ack", {31'd0, host_bg_n}, 32'd1);
        to_neg();
        xholda = 1'b1;
        after_pos();
        chk("R12 grant after ack", {31'd0, host_bg_n}, 32'd0);
        to_neg();
        host_br_n = 1'b1;
        host_bb_n = 1'b0;
        after_pos();
        chk("R12 grant kept while busy", {31'd0, host_bg_n}, 32'd0);
        chk("R12 hold kept while busy", {31'd0, xhold}, 32'd1);
        to_neg();
        host_bb_n = 1'b1;
        after_pos();
        chk("R12 grant dropped", {31'd0, host_bg_n}, 32'd1);
        chk("R12 hold dropped", {31'd0, xhold}, 32'd0);
        to_neg();
        xholda = 1'b0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule